// File: doc/BRIEF.md
# Rectangle Fill and Screen Copy Engine

This engine draws solid rectangles and copies rectangular regions from one part of a byte-addressed frame buffer to another. Software programs a small set of word-wide registers (source corner, destination corner, rectangle size, fill colour, row pitches) and then writes the control word with its start bit set. From the next cycle the engine owns a single-cycle byte memory port and walks the rectangle row by row until it is done.

A fill writes the low byte of the colour register to every byte of the destination rectangle, one byte per clock. A copy moves one byte every two clocks: a read from the source address, then a write to the destination address. Because the walk can run either forward or backward, a copy between overlapping regions keeps the original source data, provided software picks the direction by the overlap rule. A busy flag in the status register tells software when the rectangle is complete.

Top module: `blit_engine`

## Requirements
- R1: After reset every register reads zero, the status busy flag (bit 3) reads 0 and the memory port does not write.
- R2: Writing the control word with bit 31 set, a command code of 0 or 1 and a non-zero width and height launches an operation; busy reads 1 from the next cycle until the last byte has been written, and bit 31 of the control word always reads back as 0.
- R3: While busy is set, every register write is ignored, including a second start; the operation in progress and the register contents are unchanged.
- R4: Corner and size registers hold x (or width in bytes) in bits 31:16 and y (or height) in bits 15:0; the pitch register holds the destination pitch in bits 31:16 and the source pitch in bits 15:0; the byte address of a point is y times the pitch plus x.
- R5: Command code 1 in control bits 19:16 fills the destination rectangle with bits 7:0 of the colour register, one byte written per cycle, so busy lasts exactly width times height cycles, and no byte outside the rectangle changes.
- R6: Command code 0 copies the source rectangle to the destination rectangle; each byte takes one read cycle then one write cycle, so busy lasts exactly twice width times height cycles.
- R7: With control bit 27 set, the corner registers hold the last byte of each rectangle (x+w-1, y+h-1) and the walk runs right to left, bottom to top; with it clear the corner registers hold the first byte and the walk runs left to right, top to bottom. Choosing reverse when source y is below destination y, or when they are equal and source x is below destination x, makes overlapping copies reproduce the original source.
- R8: A start with any other command code, or with a width or height of zero, launches nothing: busy stays 0 and memory is untouched.
- R9: The memory port never writes while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (3) | Register word index: 0 source corner, 1 destination corner, 2 size, 3 control, 4 colour, 5 pitch, 6 status |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for the register at reg_addr, combinational |
| mem_addr | output | ADDR_W (32) | Frame buffer byte address |
| mem_we | output | 1 | Frame buffer write enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Byte read at mem_addr in the same cycle |

## Verification
The assertions take for granted that the frame buffer returns read data combinationally in the cycle the address is shown, and that software only launches copies whose direction follows the overlap rule. The bench's memory model answers in the same cycle, every random copy derives its direction bit from the source and destination corners, and all rectangles are placed so that every address stays inside the modelled buffer. Register writes during busy are issued only in the dedicated test of that case.

// File: rtl/blit_pkg.sv
package blit_pkg;

   localparam int unsigned RA_SRC    = 0;
   localparam int unsigned RA_DST    = 1;
   localparam int unsigned RA_SIZE   = 2;
   localparam int unsigned RA_CTRL   = 3;
   localparam int unsigned RA_COLOUR = 4;
   localparam int unsigned RA_PITCH  = 5;
   localparam int unsigned RA_STATUS = 6;

   localparam int unsigned CTRL_GO_BIT  = 31;
   localparam int unsigned CTRL_REV_BIT = 27;
   localparam int unsigned CTRL_OP_LSB  = 16;
   localparam int unsigned CTRL_OP_W    = 4;
   localparam int unsigned STAT_BUSY_BIT = 3;

   localparam logic [CTRL_OP_W-1:0] OP_COPY = 4'd0;
   localparam logic [CTRL_OP_W-1:0] OP_FILL = 4'd1;

   typedef enum logic [1:0] {
      WS_IDLE  = 2'd0,
      WS_READ  = 2'd1,
      WS_WRITE = 2'd2,
      WS_FILL  = 2'd3
   } walk_state_e;

endpackage

// File: rtl/blit_regs.sv
module blit_regs
   import blit_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned REG_AW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              busy,
   output logic              launch,
   output logic              launch_fill,
   output logic              dir_rev,
   output logic [DATA_W-1:0] src_xy,
   output logic [DATA_W-1:0] dst_xy,
   output logic [DATA_W-1:0] size_wh,
   output logic [DATA_W-1:0] colour,
   output logic [DATA_W-1:0] pitch
);
   localparam int unsigned HALF = DATA_W / 2;

   logic [DATA_W-1:0] src_q, dst_q, size_q, ctrl_q, col_q, pitch_q;
   logic [DATA_W-1:0] size_new;
   logic [CTRL_OP_W-1:0] op_new;
   logic wr_ok, op_ok, dims_ok;

   assign wr_ok    = reg_we && !busy;
   assign op_new   = reg_wdata[CTRL_OP_LSB +: CTRL_OP_W];
   assign op_ok    = (op_new == OP_COPY) || (op_new == OP_FILL);
   assign size_new = size_q;
   assign dims_ok  = (size_new[DATA_W-1:HALF] != '0) && (size_new[HALF-1:0] != '0);

   assign launch      = wr_ok && (reg_addr == REG_AW'(RA_CTRL)) &&
                        reg_wdata[CTRL_GO_BIT] && op_ok && dims_ok;
   assign launch_fill = (op_new == OP_FILL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q   <= '0;
         dst_q   <= '0;
         size_q  <= '0;
         ctrl_q  <= '0;
         col_q   <= '0;
         pitch_q <= '0;
      end else if (wr_ok) begin
         case (reg_addr)
            REG_AW'(RA_SRC):    src_q   <= reg_wdata;
            REG_AW'(RA_DST):    dst_q   <= reg_wdata;
            REG_AW'(RA_SIZE):   size_q  <= reg_wdata;
            REG_AW'(RA_COLOUR): col_q   <= reg_wdata;
            REG_AW'(RA_PITCH):  pitch_q <= reg_wdata;
            REG_AW'(RA_CTRL): begin
               ctrl_q <= reg_wdata;
               ctrl_q[CTRL_GO_BIT] <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_AW'(RA_SRC):    reg_rdata = src_q;
         REG_AW'(RA_DST):    reg_rdata = dst_q;
         REG_AW'(RA_SIZE):   reg_rdata = size_q;
         REG_AW'(RA_CTRL):   reg_rdata = ctrl_q;
         REG_AW'(RA_COLOUR): reg_rdata = col_q;
         REG_AW'(RA_PITCH):  reg_rdata = pitch_q;
         REG_AW'(RA_STATUS): reg_rdata[STAT_BUSY_BIT] = busy;
         default:            reg_rdata = '0;
      endcase
   end

   assign dir_rev = ctrl_q[CTRL_REV_BIT];
   assign src_xy  = src_q;
   assign dst_xy  = dst_q;
   assign size_wh = size_q;
   assign colour  = col_q;
   assign pitch   = pitch_q;
endmodule

// File: rtl/blit_walker.sv
module blit_walker #(
   parameter int unsigned COORD_W    = 16,
   parameter int unsigned ADDR_W     = 32,
   parameter bit          REVERSE_EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic                 step,
   input  logic                 rev,
   input  logic [2*COORD_W-1:0] src_xy,
   input  logic [2*COORD_W-1:0] dst_xy,
   input  logic [2*COORD_W-1:0] size_wh,
   input  logic [2*COORD_W-1:0] pitch,
   output logic [ADDR_W-1:0]    src_addr,
   output logic [ADDR_W-1:0]    dst_addr,
   output logic                 last
);
   localparam int unsigned LW = 2 * COORD_W;
   localparam logic [COORD_W-1:0] ONE = COORD_W'(1);

   logic [COORD_W-1:0] cx_q, cy_q;
   logic [COORD_W-1:0] w, h;
   logic [COORD_W-1:0] sx, sy, dx, dy;
   logic [LW-1:0]      s_lin, d_lin;
   logic               row_end;

   assign w = size_wh[LW-1:COORD_W];
   assign h = size_wh[COORD_W-1:0];
   assign row_end = (cx_q == w - ONE);
   assign last    = row_end && (cy_q == h - ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cx_q <= '0;
         cy_q <= '0;
      end else if (load) begin
         cx_q <= '0;
         cy_q <= '0;
      end else if (step) begin
         if (row_end) begin
            cx_q <= '0;
            cy_q <= cy_q + ONE;
         end else begin
            cx_q <= cx_q + ONE;
         end
      end
   end

   generate
      if (REVERSE_EN) begin : g_bidir
         always_comb begin
            if (rev) begin
               sx = src_xy[LW-1:COORD_W] - cx_q;
               sy = src_xy[COORD_W-1:0]  - cy_q;
               dx = dst_xy[LW-1:COORD_W] - cx_q;
               dy = dst_xy[COORD_W-1:0]  - cy_q;
            end else begin
               sx = src_xy[LW-1:COORD_W] + cx_q;
               sy = src_xy[COORD_W-1:0]  + cy_q;
               dx = dst_xy[LW-1:COORD_W] + cx_q;
               dy = dst_xy[COORD_W-1:0]  + cy_q;
            end
         end
      end else begin : g_fwd
         always_comb begin
            sx = src_xy[LW-1:COORD_W] + cx_q;
            sy = src_xy[COORD_W-1:0]  + cy_q;
            dx = dst_xy[LW-1:COORD_W] + cx_q;
            dy = dst_xy[COORD_W-1:0]  + cy_q;
         end
      end
   endgenerate

   assign s_lin = LW'(sy) * LW'(pitch[COORD_W-1:0]) + LW'(sx);
   assign d_lin = LW'(dy) * LW'(pitch[LW-1:COORD_W]) + LW'(dx);

   assign src_addr = s_lin[ADDR_W-1:0];
   assign dst_addr = d_lin[ADDR_W-1:0];
endmodule

// File: rtl/blit_seq.sv
module blit_seq
   import blit_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        launch,
   input  logic        launch_fill,
   input  logic        last,
   input  logic [7:0]  fill_byte,
   input  logic [7:0]  rd_byte,
   output walk_state_e state,
   output logic        busy,
   output logic        load,
   output logic        step,
   output logic        use_src,
   output logic        wr_en,
   output logic [7:0]  wr_byte
);
   walk_state_e st_q, st_d;
   logic [7:0]  hold_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         WS_IDLE:  if (launch) st_d = launch_fill ? WS_FILL : WS_READ;
         WS_READ:  st_d = WS_WRITE;
         WS_WRITE: st_d = last ? WS_IDLE : WS_READ;
         WS_FILL:  st_d = last ? WS_IDLE : WS_FILL;
         default:  st_d = WS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= WS_IDLE;
         hold_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == WS_READ) hold_q <= rd_byte;
      end
   end

   assign state   = st_q;
   assign busy    = (st_q != WS_IDLE);
   assign load    = (st_q == WS_IDLE) && launch;
   assign step    = (st_q == WS_WRITE) || (st_q == WS_FILL);
   assign wr_en   = step;
   assign use_src = (st_q == WS_READ);
   assign wr_byte = (st_q == WS_FILL) ? fill_byte : hold_q;
endmodule

// File: rtl/blit_engine.sv
module blit_engine
   import blit_pkg::*;
#(
   parameter int unsigned COORD_W    = 16,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned REG_AW     = 3,
   parameter bit          REVERSE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_we,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);
   generate
      if (DATA_W != 2 * COORD_W) begin : g_bad_pack
         $error("DATA_W must hold two coordinates");
      end
      if (ADDR_W > 2 * COORD_W) begin : g_bad_addr
         $error("ADDR_W exceeds the linear address width");
      end
      if (REG_AW < 3) begin : g_bad_aw
         $error("REG_AW too small for the register map");
      end
   endgenerate

   logic              busy, launch, launch_fill, dir_rev;
   logic              load, step, use_src, last;
   logic [DATA_W-1:0] src_xy, dst_xy, size_wh, colour, pitch;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   walk_state_e       state;

   blit_regs #(.DATA_W(DATA_W), .REG_AW(REG_AW)) u_regs (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .busy, .launch, .launch_fill, .dir_rev,
      .src_xy, .dst_xy, .size_wh, .colour, .pitch
   );

   blit_walker #(.COORD_W(COORD_W), .ADDR_W(ADDR_W), .REVERSE_EN(REVERSE_EN)) u_walk (
      .clk, .rst_n, .load, .step, .rev(dir_rev),
      .src_xy, .dst_xy, .size_wh, .pitch,
      .src_addr, .dst_addr, .last
   );

   blit_seq u_seq (
      .clk, .rst_n, .launch, .launch_fill, .last,
      .fill_byte(colour[7:0]), .rd_byte(mem_rdata),
      .state, .busy, .load, .step, .use_src,
      .wr_en(mem_we), .wr_byte(mem_wdata)
   );

   assign mem_addr = use_src ? src_addr : dst_addr;
endmodule

// File: rtl/blit_engine_chk.sv
module blit_engine_chk
   import blit_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              mem_we,
   input walk_state_e       state,
   input logic [DATA_W-1:0] src_xy,
   input logic [DATA_W-1:0] dst_xy,
   input logic [DATA_W-1:0] size_wh,
   input logic [DATA_W-1:0] colour
);
   // R9: idle engine keeps the memory port quiet
   a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_we);

   // R5: a fill writes on every busy cycle
   a_r5_fill_every_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state == WS_FILL) |-> mem_we);

   // R6: in a copy, a write is followed by a read cycle or by idle
   a_r6_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && state == WS_WRITE) |=> !mem_we);

   // R6: in a copy, a read cycle is always followed by a write
   a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && state != WS_FILL && !mem_we) |=> mem_we);

   // R3: parameters hold while busy
   a_r3_params_hold: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || ($stable(src_xy) && $stable(dst_xy) &&
                          $stable(size_wh) && $stable(colour))));

   // R2: busy drops only after a final write
   a_r2_end_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(mem_we));
endmodule

bind blit_engine blit_engine_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .state(state),
   .src_xy(src_xy), .dst_xy(dst_xy), .size_wh(size_wh), .colour(colour)
);

// File: tb/tb_blit_engine.sv
module tb_blit_engine;
   localparam int FB = 4096;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [31:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;

   logic [7:0] fb [0:FB-1];
   logic [7:0] ex [0:FB-1];
   logic [7:0] sn [0:FB-1];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   blit_engine dut (
      .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
      .mem_addr, .mem_we, .mem_wdata, .mem_rdata
   );

   assign mem_rdata = fb[mem_addr[11:0]];
   always @(posedge clk) if (mem_we) fb[mem_addr[11:0]] <= mem_wdata;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 3'(a);
      #1 d = reg_rdata;
   endtask

   function automatic logic [31:0] pk(input int hi, input int lo);
      return {hi[15:0], lo[15:0]};
   endfunction

   // Launch and count busy cycles at negedges
   task automatic launch(input logic [31:0] ctrl, output int cyc);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 3'd3; reg_wdata = ctrl;
      @(negedge clk);
      reg_we = 1'b0;
      cyc = 0;
      while (dut.mem_we === 1'bx) @(negedge clk);
      reg_addr = 3'd6;
      #1;
      while (reg_rdata[3]) begin
         cyc++;
         @(negedge clk);
         #1;
      end
   endtask

   function automatic int diff_count();
      int n = 0;
      for (int i = 0; i < FB; i++) if (fb[i] !== ex[i]) n++;
      return n;
   endfunction

   // Full operation: corners given as top-left; bench derives reverse coordinates
   task automatic op(input bit fill, input bit rev, input int sx, input int sy,
                     input int dx, input int dy, input int w, input int h,
                     input logic [7:0] col, input int ps, input int pd, input string req);
      int cyc, bad;
      logic [31:0] ctrl;
      for (int i = 0; i < FB; i++) begin sn[i] = fb[i]; ex[i] = fb[i]; end
      for (int r = 0; r < h; r++)
         for (int c = 0; c < w; c++)
            ex[(dy + r) * pd + dx + c] = fill ? col : sn[(sy + r) * ps + sx + c];
      wr(5, pk(pd, ps));
      wr(2, pk(w, h));
      wr(4, {24'h5a5a5a, col});
      if (rev) begin
         wr(0, pk(sx + w - 1, sy + h - 1));
         wr(1, pk(dx + w - 1, dy + h - 1));
      end else begin
         wr(0, pk(sx, sy));
         wr(1, pk(dx, dy));
      end
      ctrl = 32'h8000_0000 | (fill ? 32'h0001_0000 : 32'h0) | (rev ? 32'h0800_0000 : 32'h0);
      launch(ctrl, cyc);
      bad = diff_count();
      check(bad == 0, req, bad, 0);
      check(cyc == (fill ? w * h : 2 * w * h), fill ? "R5 busy length" : "R6 busy length",
            cyc, fill ? w * h : 2 * w * h);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int cyc, bad, seed;
      seed = $urandom(32'd2718);
      for (int i = 0; i < FB; i++) fb[i] = 8'(i * 7 + 3);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 7; a++) begin
         rd(a, d);
         check(d == 0, "R1 reset register", d, 0);
      end
      check(mem_we == 1'b0, "R1 no write after reset", mem_we, 0);

      // R5 fill corner cases
      op(1, 0, 0, 0, 0, 0, 1, 1, 8'hc3, 64, 64, "R5 fill 1x1");
      op(1, 0, 0, 0, 0, 10, 64, 2, 8'h11, 64, 64, "R5 fill full rows");
      op(1, 1, 0, 0, 5, 20, 7, 3, 8'h9e, 64, 64, "R7 reverse fill");

      // R2 start bit reads back clear, other control bits kept
      rd(3, d);
      check(d[31] == 1'b0, "R2 start self-clears", d[31], 0);
      check(d[19:16] == 4'd1 && d[27], "R2 control readback", d[27:16], 12'h801);

      // R6 forward overlap copy (source below destination)
      op(0, 0, 4, 12, 2, 10, 9, 5, 8'h0, 64, 64, "R6 forward overlap copy");
      // R7 reverse overlap copy, same row, shift right by one
      op(0, 1, 10, 30, 11, 30, 12, 1, 8'h0, 64, 64, "R7 reverse same-row copy");
      // R7 reverse overlap copy, source above destination
      op(0, 1, 20, 40, 22, 43, 8, 6, 8'h0, 64, 64, "R7 reverse overlap copy");
      // R4 distinct source and destination pitches
      op(0, 0, 3, 2, 40, 50, 6, 4, 8'h0, 32, 64, "R4 pitch fields");

      // R8 invalid command code and zero sizes
      for (int i = 0; i < FB; i++) ex[i] = fb[i];
      wr(2, pk(4, 4));
      launch(32'h8005_0000, cyc);
      check(cyc == 0, "R8 bad command busy", cyc, 0);
      wr(2, pk(0, 4));
      launch(32'h8001_0000, cyc);
      check(cyc == 0, "R8 zero width busy", cyc, 0);
      wr(2, pk(4, 0));
      launch(32'h8000_0000, cyc);
      check(cyc == 0, "R8 zero height busy", cyc, 0);
      bad = diff_count();
      check(bad == 0, "R8 memory untouched", bad, 0);

      // R3 writes while busy are ignored
      for (int i = 0; i < FB; i++) begin sn[i] = fb[i]; ex[i] = fb[i]; end
      for (int r = 0; r < 4; r++) for (int c = 0; c < 8; c++) ex[(60 + r) * 64 + c] = 8'h3c;
      wr(5, pk(64, 64));
      wr(1, pk(0, 60));
      wr(2, pk(8, 4));
      wr(4, 32'h3c);
      wr(3, 32'h8001_0000);
      wr(4, 32'hff);
      wr(1, pk(30, 0));
      wr(3, 32'h8000_0000);
      reg_addr = 3'd6;
      #1;
      while (reg_rdata[3]) begin @(negedge clk); #1; end
      bad = diff_count();
      check(bad == 0, "R3 busy writes ignored (memory)", bad, 0);
      rd(4, d);
      check(d == 32'h3c, "R3 colour unchanged", d, 32'h3c);
      rd(1, d);
      check(d == pk(0, 60), "R3 destination unchanged", d, pk(0, 60));
      check(mem_we == 1'b0, "R9 idle no write", mem_we, 0);

      // Random operations; direction chosen by the overlap rule (R7)
      for (int k = 0; k < 30; k++) begin
         int w, h, sx, sy, dx, dy;
         bit fl, rv;
         w  = $urandom_range(1, 16);
         h  = $urandom_range(1, 8);
         sx = $urandom_range(0, 64 - w);
         sy = $urandom_range(0, 64 - h);
         if ($urandom_range(0, 1)) begin
            dx = sx + $urandom_range(0, 2) - 1; if (dx < 0) dx = 0; if (dx > 64 - w) dx = 64 - w;
            dy = sy + $urandom_range(0, 2) - 1; if (dy < 0) dy = 0; if (dy > 64 - h) dy = 64 - h;
         end else begin
            dx = $urandom_range(0, 64 - w);
            dy = $urandom_range(0, 64 - h);
         end
         fl = ($urandom_range(0, 3) == 0);
         rv = (sy < dy) || (sy == dy && sx < dx);
         op(fl, rv, sx, sy, dx, dy, w, h, 8'($urandom), 64, 64,
            fl ? "R5 random fill" : "R7 random copy");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule